// File: doc/BRIEF.md
# Timer Command and Control Unit

This block is an up/down timer whose control byte is written through two strobed ports. One port sets bits and the other clears bits. Software can therefore change a single control bit without first reading the register. The control byte holds a three-bit command field, a one-shot enable, an update-lock bit and a count-direction bit. A write does not land at once. A small synchronizer state machine holds the write for `SYNC_LAT` clock cycles and raises a busy flag during that time. Once the write has landed, any non-zero command waits for the next prescaled counter tick (`cnt_tick`). It runs on that tick and then clears itself.

The counter steps once per tick while running, between zero and an active period value. Active period and compare values are double-buffered. Software writes the buffers directly. Each wrap of the counter copies the buffers into the active registers unless the lock bit is set. A forced-update command always copies. Other commands start or restart the counter, stop it, capture a snapshot of the count, or emit a one-cycle trigger pulse.

Synchronizer states are `ST_IDLE`, `ST_SYNC` and `ST_ARMED`:
- `ST_IDLE` to `ST_SYNC` on an accepted write.
- `ST_SYNC` to `ST_ARMED` when the landed command field is non-zero.
- `ST_SYNC` to `ST_IDLE` when the landed command field is zero.
- `ST_ARMED` to `ST_IDLE` on a tick, when the command runs.

Counter states are `CNT_HALT` and `CNT_RUN`:
- `CNT_HALT` or `CNT_RUN` to `CNT_RUN` on a retrigger.
- Either state to `CNT_HALT` on a stop command.
- `CNT_RUN` to `CNT_HALT` on a wrap while one-shot is set.

Top module: `tmr_ctl_unit`

## Requirements
- R1: After reset the control readback is 0x00, the busy flag is 0, count is 0, the counter is halted and both active registers are 0.
- R2: The control byte has the command in bits 7:5, one-shot in bit 2, lock in bit 1 and direction in bit 0. Each 1 written on the set port sets that bit and each 0 leaves it unchanged. Busy is high for exactly `SYNC_LAT` cycles after the write edge, and the new value is read back when busy falls.
- R3: Each 1 on the clear port clears that bit. Any 1 in bits 7:5 of the clear data cancels the command field. When set and clear are strobed in the same cycle, the clear wins for every bit they share.
- R4: A write strobed while busy is high, or while a command is waiting for its tick, is ignored.
- R5: Command codes are 0 none, 1 retrigger, 2 stop, 3 force update, 4 count snapshot, 5 trigger pulse. A command runs on the first tick after its write lands and then reads back as 0. Codes 6 and 7 land as 0 and do nothing.
- R6: Retrigger starts the counter. The count is loaded with 0 when direction is 0, and with the active period when direction is 1.
- R7: Stop halts the counter, and the count holds through later ticks.
- R8: While running, each tick increments the count, or decrements it when direction is 1. Counting up from a count at or above the period gives 0; counting down from 0 gives the period. Both are wraps, and `wrap_evt` is high for the cycle after a wrap.
- R9: With one-shot set, the counter wraps once and then halts.
- R10: A wrap copies the period and compare buffers into the active registers unless lock is set. After lock is cleared, the next wrap copies.
- R11: Force update copies both buffers into the active registers even while lock is set.
- R12: The snapshot command loads `snap_count` with the count from before that tick, and `snap_vld` is high for one cycle. The trigger command raises `dma_trig` for one cycle.
- R13: Bits 4:3 of the control byte read as 0 and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_tick | input | 1 | Prescaled counter enable |
| ctl_set_wr | input | 1 | Set-port write strobe |
| ctl_set_data | input | 8 | Bits to set |
| ctl_clr_wr | input | 1 | Clear-port write strobe |
| ctl_clr_data | input | 8 | Bits to clear |
| ctl_rdata | output | 8 | Control readback, shared by both ports |
| sync_busy | output | 1 | Write pending synchronization |
| per_buf_wr | input | 1 | Period buffer write strobe |
| per_buf_data | input | CNT_W | Period buffer data |
| cmp_buf_wr | input | 1 | Compare buffer write strobe |
| cmp_buf_data | input | CNT_W | Compare buffer data |
| per_active | output | CNT_W | Active period |
| cmp_active | output | CNT_W | Active compare value |
| count | output | CNT_W | Counter value |
| running | output | 1 | Counter in `CNT_RUN` |
| wrap_evt | output | 1 | One-cycle wrap indication |
| snap_count | output | CNT_W | Count snapshot |
| snap_vld | output | 1 | Snapshot taken last edge |
| dma_trig | output | 1 | One-cycle trigger pulse |

## Verification
- Busy is due the cycle after the write edge. The landed control value and the fall of busy are due `SYNC_LAT` edges later.
- A command's effect, the zero readback of its field and any pulse are all due right after the first edge that has `cnt_tick` high once the write has landed. A counter step or wrap appears after its tick edge in the same way.
- The bench drives inputs on falling edges and samples on the falling edge after the edge on which a result is due. It holds `cnt_tick` low during writes, so its arithmetic model of count, period and flags advances only on ticks it issued itself.

// File: rtl/tmr_ctl_pkg.sv
`timescale 1ns/1ps
package tmr_ctl_pkg;

    typedef enum logic [2:0] {
        CMD_NONE   = 3'd0,
        CMD_RETRIG = 3'd1,
        CMD_STOP   = 3'd2,
        CMD_UPDATE = 3'd3,
        CMD_RDSYNC = 3'd4,
        CMD_DMAOS  = 3'd5
    } cmd_e;

    localparam logic [2:0] CMD_MAX = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SYNC  = 2'd1,
        ST_ARMED = 2'd2
    } sync_st_e;

    typedef enum logic {
        CNT_HALT = 1'b0,
        CNT_RUN  = 1'b1
    } run_st_e;

    typedef struct packed {
        logic [2:0] cmd;
        logic       oneshot;
        logic       lock;
        logic       dir;
    } ctl_t;

    // Combine one pending set/clear pair with the current control value.
    function automatic ctl_t ctl_merge(ctl_t cur, logic [7:0] s, logic [7:0] c);
        ctl_t r;
        r         = cur;
        r.dir     = (cur.dir     | s[0]) & ~c[0];
        r.lock    = (cur.lock    | s[1]) & ~c[1];
        r.oneshot = (cur.oneshot | s[2]) & ~c[2];
        if (c[7:5] != 3'd0) begin
            r.cmd = 3'd0;
        end else if (s[7:5] != 3'd0) begin
            r.cmd = (s[7:5] <= CMD_MAX) ? s[7:5] : 3'd0;
        end
        return r;
    endfunction

endpackage

// File: rtl/tmr_ctl_regs.sv
`timescale 1ns/1ps
module tmr_ctl_regs
    import tmr_ctl_pkg::*;
#(
    parameter int SYNC_LAT = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       set_wr,
    input  logic [7:0] set_data,
    input  logic       clr_wr,
    input  logic [7:0] clr_data,
    output ctl_t       ctl,
    output logic       busy,
    output logic       exec_vld,
    output logic [2:0] exec_cmd
);

    localparam int CW = $clog2(SYNC_LAT) + 1;

    sync_st_e       state;
    sync_st_e       state_nx;
    logic [CW-1:0]  sync_cnt;
    logic [7:0]     pend_set;
    logic [7:0]     pend_clr;
    ctl_t           merged;
    logic           accept;
    logic           land;
    logic           unused_idx_bits;

    assign unused_idx_bits = ^{pend_set[4:3], pend_clr[4:3]};

    assign accept = (state == ST_IDLE) && (set_wr || clr_wr);
    assign land   = (state == ST_SYNC) && (sync_cnt == '0);
    assign merged = ctl_merge(ctl, pend_set, pend_clr);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = ST_SYNC;
            ST_SYNC:  if (land)   state_nx = (merged.cmd != 3'd0) ? ST_ARMED : ST_IDLE;
            ST_ARMED: if (tick)   state_nx = ST_IDLE;
            default:              state_nx = ST_IDLE;
        endcase
    end

    // data held across the synchronizer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_cnt <= '0;
            pend_set <= '0;
            pend_clr <= '0;
            ctl      <= '0;
        end else begin
            if (accept) begin
                pend_set <= set_wr ? set_data : 8'h00;
                pend_clr <= clr_wr ? clr_data : 8'h00;
                sync_cnt <= CW'(SYNC_LAT - 1);
            end else if (state == ST_SYNC && !land) begin
                sync_cnt <= sync_cnt - 1'b1;
            end
            if (land) begin
                ctl <= merged;
            end else if (exec_vld) begin
                ctl.cmd <= 3'd0;
            end
        end
    end

    // outputs
    always_comb begin
        busy     = (state == ST_SYNC);
        exec_vld = (state == ST_ARMED) && tick;
        exec_cmd = ctl.cmd;
    end

    // R2: busy only ever rises after an accepted strobe
    a_r2_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(set_wr || clr_wr));

    // R4: no strobe alters the control value before the write lands
    a_r4_ctl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC && sync_cnt != '0) |=> $stable(ctl));

    // R5: a run command reads back as zero afterwards
    a_r5_cmd_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        exec_vld |=> (ctl.cmd == 3'd0));

    // R5: reserved codes never reach the command field
    a_r5_cmd_legal: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.cmd <= CMD_MAX);

endmodule

// File: rtl/tmr_ctl_buf.sv
`timescale 1ns/1ps
module tmr_ctl_buf #(
    parameter int W   = 8,
    parameter int NCH = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCH-1:0]          buf_wr,
    input  logic [NCH-1:0][W-1:0]   buf_d,
    input  logic                    hw_upd,
    input  logic                    force_upd,
    input  logic                    lock,
    output logic [NCH-1:0][W-1:0]   act
);

    logic [W-1:0] buf_q [NCH];
    logic [W-1:0] act_q [NCH];
    logic         copy_en;

    assign copy_en = force_upd || (hw_upd && !lock);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                buf_q[i] <= '0;
                act_q[i] <= '0;
            end else begin
                if (buf_wr[i]) buf_q[i] <= buf_d[i];
                if (copy_en)   act_q[i] <= buf_q[i];
            end
        end
        assign act[i] = act_q[i];
    end

    // R10: a locked hardware update leaves the active period alone
    a_r10_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_upd && lock && !force_upd) |=> $stable(act[0]));

    // R11: forced update always copies the buffer
    a_r11_force_copies: assert property (@(posedge clk) disable iff (!rst_n)
        force_upd |=> (act[0] == $past(buf_q[0])));

endmodule

// File: rtl/tmr_ctl_count.sv
`timescale 1ns/1ps
module tmr_ctl_count
    import tmr_ctl_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         dir,
    input  logic         oneshot,
    input  logic         exec_vld,
    input  logic [2:0]   exec_cmd,
    input  logic [W-1:0] per_act,
    output logic [W-1:0] count,
    output logic         running,
    output logic         hw_upd,
    output logic         force_upd,
    output logic         wrap_evt,
    output logic [W-1:0] snap,
    output logic         snap_vld,
    output logic         dma_pulse
);

    run_st_e      st;
    run_st_e      st_nx;
    logic [W-1:0] cnt_nx;
    logic         do_retrig;
    logic         do_stop;
    logic         at_end;
    logic         wrap_now;

    assign do_retrig = exec_vld && (exec_cmd == CMD_RETRIG);
    assign do_stop   = exec_vld && (exec_cmd == CMD_STOP);
    assign at_end    = dir ? (count == '0) : (count >= per_act);
    assign wrap_now  = tick && (st == CNT_RUN) && !do_retrig && !do_stop && at_end;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= CNT_HALT;
        else        st <= st_nx;
    end

    // next state and next count
    always_comb begin
        st_nx  = st;
        cnt_nx = count;
        if (do_retrig) begin
            st_nx  = CNT_RUN;
            cnt_nx = dir ? per_act : '0;
        end else if (do_stop) begin
            st_nx  = CNT_HALT;
        end else begin
            unique case (st)
                CNT_RUN: begin
                    if (tick) begin
                        if (at_end) begin
                            cnt_nx = dir ? per_act : '0;
                            if (oneshot) st_nx = CNT_HALT;
                        end else begin
                            cnt_nx = dir ? (count - 1'b1) : (count + 1'b1);
                        end
                    end
                end
                CNT_HALT: st_nx = CNT_HALT;
                default:  st_nx = CNT_HALT;
            endcase
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count     <= '0;
            wrap_evt  <= 1'b0;
            snap      <= '0;
            snap_vld  <= 1'b0;
            dma_pulse <= 1'b0;
        end else begin
            count     <= cnt_nx;
            wrap_evt  <= wrap_now;
            snap_vld  <= exec_vld && (exec_cmd == CMD_RDSYNC);
            dma_pulse <= exec_vld && (exec_cmd == CMD_DMAOS);
            if (exec_vld && (exec_cmd == CMD_RDSYNC)) snap <= count;
        end
    end

    always_comb begin
        running   = (st == CNT_RUN);
        hw_upd    = wrap_now;
        force_upd = exec_vld && (exec_cmd == CMD_UPDATE);
    end

    // R9: a one-shot wrap leaves the counter halted
    a_r9_oneshot_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_now && oneshot) |=> !running);

    // R7: a halted counter holds its value unless a command runs
    a_r7_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CNT_HALT && !exec_vld) |=> $stable(count));

    // R12: the trigger pulse lasts a single cycle
    a_r12_dma_single: assert property (@(posedge clk) disable iff (!rst_n)
        dma_pulse |=> !dma_pulse);

endmodule

// File: rtl/tmr_ctl_unit.sv
`timescale 1ns/1ps
module tmr_ctl_unit
    import tmr_ctl_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int SYNC_LAT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_tick,
    input  logic             ctl_set_wr,
    input  logic [7:0]       ctl_set_data,
    input  logic             ctl_clr_wr,
    input  logic [7:0]       ctl_clr_data,
    output logic [7:0]       ctl_rdata,
    output logic             sync_busy,
    input  logic             per_buf_wr,
    input  logic [CNT_W-1:0] per_buf_data,
    input  logic             cmp_buf_wr,
    input  logic [CNT_W-1:0] cmp_buf_data,
    output logic [CNT_W-1:0] per_active,
    output logic [CNT_W-1:0] cmp_active,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             wrap_evt,
    output logic [CNT_W-1:0] snap_count,
    output logic             snap_vld,
    output logic             dma_trig
);

    localparam int NCH = 2;

    ctl_t                       ctl;
    logic                       exec_vld;
    logic [2:0]                 exec_cmd;
    logic                       hw_upd;
    logic                       force_upd;
    logic [NCH-1:0]             buf_wr;
    logic [NCH-1:0][CNT_W-1:0]  buf_d;
    logic [NCH-1:0][CNT_W-1:0]  act;

    tmr_ctl_regs #(.SYNC_LAT(SYNC_LAT)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (cnt_tick),
        .set_wr   (ctl_set_wr),
        .set_data (ctl_set_data),
        .clr_wr   (ctl_clr_wr),
        .clr_data (ctl_clr_data),
        .ctl      (ctl),
        .busy     (sync_busy),
        .exec_vld (exec_vld),
        .exec_cmd (exec_cmd)
    );

    tmr_ctl_count #(.W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (cnt_tick),
        .dir       (ctl.dir),
        .oneshot   (ctl.oneshot),
        .exec_vld  (exec_vld),
        .exec_cmd  (exec_cmd),
        .per_act   (act[0]),
        .count     (count),
        .running   (running),
        .hw_upd    (hw_upd),
        .force_upd (force_upd),
        .wrap_evt  (wrap_evt),
        .snap      (snap_count),
        .snap_vld  (snap_vld),
        .dma_pulse (dma_trig)
    );

    assign buf_wr = {cmp_buf_wr, per_buf_wr};
    assign buf_d  = {cmp_buf_data, per_buf_data};

    tmr_ctl_buf #(.W(CNT_W), .NCH(NCH)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .buf_wr    (buf_wr),
        .buf_d     (buf_d),
        .hw_upd    (hw_upd),
        .force_upd (force_upd),
        .lock      (ctl.lock),
        .act       (act)
    );

    assign per_active = act[0];
    assign cmp_active = act[1];
    // R13: index bits are not stored and read as zero
    assign ctl_rdata  = {ctl.cmd, 2'b00, ctl.oneshot, ctl.lock, ctl.dir};

endmodule

// File: tb/sim_tmr_ctl_unit.sv
`timescale 1ns/1ps
module sim_tmr_ctl_unit;

    localparam int W = 4;
    localparam int L = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_tick = 1'b0;
    logic         ctl_set_wr = 1'b0;
    logic [7:0]   ctl_set_data = '0;
    logic         ctl_clr_wr = 1'b0;
    logic [7:0]   ctl_clr_data = '0;
    logic [7:0]   ctl_rdata;
    logic         sync_busy;
    logic         per_buf_wr = 1'b0;
    logic [W-1:0] per_buf_data = '0;
    logic         cmp_buf_wr = 1'b0;
    logic [W-1:0] cmp_buf_data = '0;
    logic [W-1:0] per_active, cmp_active, count, snap_count;
    logic         running, wrap_evt, snap_vld, dma_trig;

    always #2.5 clk = ~clk;

    tmr_ctl_unit #(.CNT_W(W), .SYNC_LAT(L)) u0 (.*);

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model
    int e_cnt = 0, e_per = 0, e_cmp = 0, e_pbuf = 0, e_cbuf = 0;
    bit e_run = 0, e_dir = 0, e_os = 0, e_lock = 0;

    task automatic chk(string req, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_rd(int c);
        return (c << 5) | (int'(e_os) << 2) | (int'(e_lock) << 1) | int'(e_dir);
    endfunction

    // Strobe a write, check busy timing (R2), update model, check readback.
    task automatic wr(bit s, logic [7:0] sd, bit c, logic [7:0] cd, string req);
        int ec;
        @(negedge clk);
        ctl_set_wr = s; ctl_set_data = sd; ctl_clr_wr = c; ctl_clr_data = cd;
        @(negedge clk);
        ctl_set_wr = 0; ctl_clr_wr = 0;
        chk("R2", sync_busy, 1, "busy after write");
        repeat (L - 1) @(negedge clk);
        chk("R2", sync_busy, 1, "busy last cycle");
        @(negedge clk);
        chk("R2", sync_busy, 0, "busy after landing");
        if (!s) sd = 8'h00;
        if (!c) cd = 8'h00;
        e_dir  = (e_dir  | sd[0]) & ~cd[0];
        e_lock = (e_lock | sd[1]) & ~cd[1];
        e_os   = (e_os   | sd[2]) & ~cd[2];
        if (cd[7:5] != 0) ec = 0;
        else ec = (sd[7:5] <= 5) ? int'(sd[7:5]) : 0;
        chk(req, int'(ctl_rdata), exp_rd(ec), "readback");
    endtask

    task automatic ldbuf(int p, int c);
        @(negedge clk);
        per_buf_wr = 1; per_buf_data = W'(p); cmp_buf_wr = 1; cmp_buf_data = W'(c);
        @(negedge clk);
        per_buf_wr = 0; cmp_buf_wr = 0;
        e_pbuf = p; e_cbuf = c;
    endtask

    // One tick with an optional armed command pc; checks results after the edge.
    task automatic tick(int pc, string req);
        int old; bit wrp;
        old = e_cnt; wrp = 0;
        if (pc == 1) begin
            e_run = 1; e_cnt = e_dir ? e_per : 0;
        end else if (pc == 2) begin
            e_run = 0;
        end else if (e_run) begin
            if (e_dir ? (e_cnt == 0) : (e_cnt >= e_per)) begin
                wrp = 1; e_cnt = e_dir ? e_per : 0;
                if (e_os) e_run = 0;
                if (!e_lock) begin e_per = e_pbuf; e_cmp = e_cbuf; end
            end else begin
                e_cnt = e_dir ? e_cnt - 1 : e_cnt + 1;
            end
        end
        if (pc == 3) begin e_per = e_pbuf; e_cmp = e_cbuf; end
        @(negedge clk); cnt_tick = 1;
        @(negedge clk); cnt_tick = 0;
        chk(req, int'(count), e_cnt, "count");
        chk(req, int'(running), int'(e_run), "running");
        chk("R8", int'(wrap_evt), int'(wrp), "wrap_evt");
        chk(req, int'(per_active), e_per, "per_active");
        chk(req, int'(cmp_active), e_cmp, "cmp_active");
        chk("R5", int'(ctl_rdata[7:5]), 0, "cmd after tick");
        chk("R12", int'(snap_vld), int'(pc == 4), "snap_vld");
        chk("R12", int'(dma_trig), int'(pc == 5), "dma_trig");
        if (pc == 4) chk("R12", int'(snap_count), old, "snap_count");
    endtask

    task automatic run_cmd(int c, string req);
        wr(1, {3'(c), 5'b0}, 0, 8'h00, "R5");
        tick(c, req);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk("R1", int'(ctl_rdata), 0, "rdata");
        chk("R1", int'(sync_busy), 0, "busy");
        chk("R1", int'(count), 0, "count");
        chk("R1", int'(running), 0, "running");
        chk("R1", int'(per_active), 0, "per_active");

        // R13 and R2: index bits ignored, other bits set
        wr(1, 8'h1F, 0, 8'h00, "R13");
        // R3: clear port
        wr(0, 8'h00, 1, 8'h05, "R3");
        // R3: clear wins over simultaneous set
        wr(1, 8'h05, 1, 8'h03, "R3");
        wr(1, 8'h20, 1, 8'h20, "R3");
        wr(0, 8'h00, 1, 8'h07, "R3");

        // R4: write while busy is ignored
        @(negedge clk); ctl_set_wr = 1; ctl_set_data = 8'h01;
        @(negedge clk); ctl_set_data = 8'h02;
        @(negedge clk); ctl_set_wr = 0;
        repeat (L - 1) @(negedge clk);
        chk("R4", int'(ctl_rdata), 8'h01, "second write ignored");
        chk("R4", int'(sync_busy), 0, "busy after ignored write");
        e_dir = 1;
        wr(0, 8'h00, 1, 8'h01, "R3");

        // R5: reserved codes land as zero
        wr(1, 8'hC0, 0, 8'h00, "R5");
        wr(1, 8'hE0, 0, 8'h00, "R5");

        // R5/R11/R6/R8: sweep of periods counting up
        foreach (e_pbuf_list[i]) begin
            ldbuf(e_pbuf_list[i], e_pbuf_list[i] / 2);
            run_cmd(3, "R11");
            run_cmd(1, "R6");
            for (int k = 0; k < 2 * (e_pbuf_list[i] + 1) + 1; k++) tick(0, "R8");
        end

        // R7: stop and hold
        run_cmd(2, "R7");
        for (int k = 0; k < 3; k++) tick(0, "R7");

        // R8: count down
        ldbuf(6, 2);
        run_cmd(3, "R11");
        wr(1, 8'h01, 0, 8'h00, "R2");
        run_cmd(1, "R6");
        for (int k = 0; k < 16; k++) tick(0, "R8");

        // R9: one-shot, both directions
        wr(1, 8'h04, 0, 8'h00, "R9");
        run_cmd(1, "R9");
        for (int k = 0; k < 10; k++) tick(0, "R9");
        chk("R9", int'(running), 0, "halted after one-shot down");
        wr(0, 8'h00, 1, 8'h01, "R9");
        run_cmd(1, "R9");
        for (int k = 0; k < 10; k++) tick(0, "R9");
        chk("R9", int'(running), 0, "halted after one-shot up");
        wr(0, 8'h00, 1, 8'h04, "R9");

        // R10: lock blocks wrap copy, unlock lets next wrap copy
        wr(1, 8'h02, 0, 8'h00, "R10");
        ldbuf(3, 1);
        run_cmd(1, "R10");
        for (int k = 0; k < 9; k++) tick(0, "R10");
        chk("R10", int'(per_active), 6, "locked period");
        wr(0, 8'h00, 1, 8'h02, "R10");
        for (int k = 0; k < 8; k++) tick(0, "R10");
        chk("R10", int'(per_active), 3, "period after unlock");

        // R11: forced update under lock
        wr(1, 8'h02, 0, 8'h00, "R11");
        ldbuf(9, 4);
        run_cmd(3, "R11");
        chk("R11", int'(per_active), 9, "forced period");
        wr(0, 8'h00, 1, 8'h02, "R11");

        // R12: snapshot and trigger pulse
        tick(0, "R12"); tick(0, "R12");
        run_cmd(4, "R12");
        tick(0, "R12");
        // R4: write while a command is armed is ignored
        wr(1, 8'hA0, 0, 8'h00, "R12");
        @(negedge clk); ctl_set_wr = 1; ctl_set_data = 8'h01;
        @(negedge clk); ctl_set_wr = 0;
        chk("R4", int'(sync_busy), 0, "no busy while armed");
        repeat (L) @(negedge clk);
        chk("R4", int'(ctl_rdata), 8'hA0, "armed write ignored");
        tick(5, "R12");
        tick(0, "R12");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    int e_pbuf_list[5] = '{0, 1, 3, 7, 15};

endmodule